// File: doc/BRIEF.md
# Page-Decoded System Bus Router

This block sits between a processor's single memory port and the memory-mapped targets of a small system. Each cycle it takes at most one request (address, access size, read/write strobe and write data). It decodes the most significant address byte into a page and steers the request to one target. For ordinary targets it drives a select line, an aligned address, the size and the write data. In the same cycle it returns that target's read data, zero-extended to the access size.

Two pages lead to a narrow 8-bit save memory. That port gets the untouched address. On a read, the router copies the single returned byte into every lane covered by the access. On a write, it rotates the write data so that the byte matching the address offset reaches the byte port.

The cartridge ROM window accepts reads only, and writes to it vanish quietly. Pages with no target return zero and raise an error flag. A free-running counter records every request. Writes to video memory also present the current display-control value to that target.

Top module: `sysbus_router`

## Requirements
- R1: Address bits [31:24] pick the destination. Page 0x00 selects port 0, 0x02 port 1, 0x03 port 2, 0x04 port 3, 0x05 port 4, 0x06 port 5 and 0x07 port 6. At most one of `tgt_sel`/`bk_sel` is high at a time, and none is high while `req_valid` is low.
- R2: Pages 0x08 to 0x0D select port 7 on reads. A write to these pages asserts no select and raises no error.
- R3: Pages 0x0E and 0x0F assert `bk_sel` and no `tgt_sel` bit. `bk_addr` carries `req_addr` unchanged.
- R4: A read from the save pages returns `bk_rdata` copied into the lanes the access covers: once for a byte, twice for a halfword, four times for a word. Higher bits are zero.
- R5: On a save-page write, `bk_wbyte` is the low byte of `req_wdata` rotated right by 8×(addr[1:0]) for a word, 8×addr[0] for a halfword, and 0 for a byte.
- R6: `tgt_addr` is `req_addr` with bits [1:0] cleared for a word, bit 0 cleared for a halfword, and unchanged for a byte.
- R7: A valid request to page 0x01 or any page from 0x10 upward raises `rsp_err`, selects nothing and returns zero read data. `rsp_err` is low for every other page.
- R8: `acc_count` is zero after reset. It increases by one (modulo 2^CNT_W) on each clock edge where `req_valid` is high, and holds otherwise.
- R9: `vram_ctrl` equals `disp_ctrl` during a valid write to page 0x06, and is zero otherwise.
- R10: The size encoding is 2'b00 byte, 2'b01 halfword, 2'b10 word, and 2'b11 is treated as a word. A read from port p returns the low 8, 16 or 32 bits of that port's data, zero-extended. Read data is zero during writes. All responses appear in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle |
| rsp_err | output | 1 | Unmapped page hit |
| disp_ctrl | input | 16 | Current display-control value |
| vram_ctrl | output | 16 | Display control presented on video writes |
| tgt_sel | output | 8 | One select per ordinary port |
| tgt_we | output | 1 | Write strobe to ports |
| tgt_size | output | 2 | Size to ports |
| tgt_addr | output | 32 | Aligned address to ports |
| tgt_wdata | output | 32 | Write data to ports |
| tgt_rdata | input | 256 | Packed read data, port p at [32p+31:32p] |
| bk_sel | output | 1 | Save memory select |
| bk_we | output | 1 | Save memory write strobe |
| bk_addr | output | 32 | Unaligned address to save memory |
| bk_wbyte | output | 8 | Byte written to save memory |
| bk_rdata | input | 8 | Byte read from save memory |
| acc_count | output | 32 | Access counter |

## Verification
The bench builds the router with a 6-bit access counter. Its few hundred requests therefore wrap the counter several times and exercise the modulo behaviour, which the default 32-bit width would never reach. All other parameters keep their defaults: a 32-bit address and data path, eight ordinary ports and a 16-bit display-control value. Random pages are drawn from 0x00 to 0x13 and include 0xFF, with all four size codes and random offsets. Under these draws every port, the cartridge write drop, both save pages at every lane offset, and the unmapped holes below and above the map all occur many times.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    // Values 0..7 equal the ordinary port index.
    typedef enum logic [3:0] {
        DST_BOOT  = 4'd0,
        DST_XRAM  = 4'd1,
        DST_IRAM  = 4'd2,
        DST_IOREG = 4'd3,
        DST_PAL   = 4'd4,
        DST_VID   = 4'd5,
        DST_OBJ   = 4'd6,
        DST_CART  = 4'd7,
        DST_SAVE  = 4'd8,
        DST_DROP  = 4'd9,
        DST_NONE  = 4'd10
    } dest_e;

    localparam int NUM_PORTS = 8;

endpackage

// File: rtl/page_decoder.sv
module page_decoder
    import sysbus_pkg::*;
(
    input  logic [7:0] page,
    input  logic       is_write,
    output dest_e      dest
);
    always_comb begin
        unique case (page) inside
            8'h00:          dest = DST_BOOT;
            8'h02:          dest = DST_XRAM;
            8'h03:          dest = DST_IRAM;
            8'h04:          dest = DST_IOREG;
            8'h05:          dest = DST_PAL;
            8'h06:          dest = DST_VID;
            8'h07:          dest = DST_OBJ;
            [8'h08:8'h0D]:  dest = is_write ? DST_DROP : DST_CART;
            [8'h0E:8'h0F]:  dest = DST_SAVE;
            default:        dest = DST_NONE;
        endcase
    end
endmodule

// File: rtl/addr_aligner.sv
module addr_aligner
    import sysbus_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_in,
    input  logic [1:0]    size,
    output logic [AW-1:0] addr_out
);
    always_comb begin
        unique case (size)
            SZ_BYTE: addr_out = addr_in;
            SZ_HALF: addr_out = {addr_in[AW-1:1], 1'b0};
            default: addr_out = {addr_in[AW-1:2], 2'b00};
        endcase
    end
endmodule

// File: rtl/save_lane.sv
module save_lane
    import sysbus_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    size,
    input  logic [1:0]    addr_lo,
    input  logic [DW-1:0] wdata,
    input  logic [7:0]    byte_in,
    output logic [7:0]    byte_out,
    output logic [DW-1:0] rep_data
);
    localparam int LANES = DW / 8;
    localparam int SHW   = 5;

    logic [SHW-1:0]  shamt;
    logic [2*DW-1:0] rot;
    int unsigned     n_lanes;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin shamt = '0;                   n_lanes = 1; end
            SZ_HALF: begin shamt = {1'b0, addr_lo[0], 3'b000}; n_lanes = 2; end
            default: begin shamt = {addr_lo, 3'b000};      n_lanes = LANES; end
        endcase
        rot      = {wdata, wdata} >> shamt;
        byte_out = rot[7:0];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rep_data[l*8 +: 8] = (l < n_lanes) ? byte_in : 8'h00;
    end
endmodule

// File: rtl/access_counter.sv
module access_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> count == $past(count) + 1'b1);
    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
endmodule

// File: rtl/sysbus_router.sv
module sysbus_router
    import sysbus_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int CNT_W  = 32,
    parameter int DISP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_we,
    input  logic [1:0]              req_size,
    input  logic [AW-1:0]           req_addr,
    input  logic [DW-1:0]           req_wdata,
    output logic [DW-1:0]           rsp_rdata,
    output logic                    rsp_err,
    input  logic [DISP_W-1:0]       disp_ctrl,
    output logic [DISP_W-1:0]       vram_ctrl,
    output logic [NUM_PORTS-1:0]    tgt_sel,
    output logic                    tgt_we,
    output logic [1:0]              tgt_size,
    output logic [AW-1:0]           tgt_addr,
    output logic [DW-1:0]           tgt_wdata,
    input  logic [NUM_PORTS*DW-1:0] tgt_rdata,
    output logic                    bk_sel,
    output logic                    bk_we,
    output logic [AW-1:0]           bk_addr,
    output logic [7:0]              bk_wbyte,
    input  logic [7:0]              bk_rdata,
    output logic [CNT_W-1:0]        acc_count
);
    localparam int LANES = DW / 8;

    dest_e         dest;
    logic [DW-1:0] port_rd [NUM_PORTS];
    logic [DW-1:0] sel_raw;
    logic [DW-1:0] save_rep;
    logic          is_read;

    page_decoder u_dec (
        .page     (req_addr[AW-1 -: 8]),
        .is_write (req_we),
        .dest     (dest)
    );

    addr_aligner #(.AW(AW)) u_align (
        .addr_in  (req_addr),
        .size     (req_size),
        .addr_out (tgt_addr)
    );

    save_lane #(.DW(DW)) u_save (
        .size     (req_size),
        .addr_lo  (req_addr[1:0]),
        .wdata    (req_wdata),
        .byte_in  (bk_rdata),
        .byte_out (bk_wbyte),
        .rep_data (save_rep)
    );

    access_counter #(.CW(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (req_valid),
        .count (acc_count)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        assign port_rd[g] = tgt_rdata[g*DW +: DW];
        assign tgt_sel[g] = req_valid && (dest == dest_e'(g));
    end

    assign is_read   = req_valid && !req_we;
    assign sel_raw   = port_rd[dest[2:0]];
    assign tgt_we    = req_we;
    assign tgt_size  = req_size;
    assign tgt_wdata = req_wdata;
    assign bk_sel    = req_valid && (dest == DST_SAVE);
    assign bk_we     = req_we;
    assign bk_addr   = req_addr;
    assign rsp_err   = req_valid && (dest == DST_NONE);
    assign vram_ctrl = (req_valid && req_we && dest == DST_VID) ? disp_ctrl : '0;

    always_comb begin
        rsp_rdata = '0;
        if (is_read) begin
            unique case (dest)
                DST_SAVE: rsp_rdata = save_rep;
                DST_DROP, DST_NONE: rsp_rdata = '0;
                default: begin
                    unique case (req_size)
                        SZ_BYTE: rsp_rdata = {{(DW-8){1'b0}}, sel_raw[7:0]};
                        SZ_HALF: rsp_rdata = {{(DW-16){1'b0}}, sel_raw[15:0]};
                        default: rsp_rdata = sel_raw;
                    endcase
                end
            endcase
        end
    end

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tgt_sel, bk_sel}));
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (tgt_sel == '0 && !bk_sel && !rsp_err));
    assert_cart_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && req_addr[AW-1 -: 8] inside {[8'h08:8'h0D]})
        |-> (tgt_sel == '0 && !bk_sel && !rsp_err));
    assert_save_rep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_sel && !req_we && req_size == SZ_WORD) |-> rsp_rdata == {LANES{bk_rdata}});
    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0 && tgt_sel == '0 && !bk_sel));
    assert_vram_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_we) |-> vram_ctrl == '0);
endmodule

// File: tb/tb_sysbus_router.sv
module tb_sysbus_router;
    localparam int CW = 6;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_we = 0;
    logic [1:0]  req_size = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [15:0] disp_ctrl = 0, vram_ctrl;
    logic [7:0]  tgt_sel;
    logic        tgt_we;
    logic [1:0]  tgt_size;
    logic [31:0] tgt_addr, tgt_wdata;
    logic [255:0] tgt_rdata;
    logic        bk_sel, bk_we;
    logic [31:0] bk_addr;
    logic [7:0]  bk_wbyte, bk_rdata;
    logic [CW-1:0] acc_count;

    int n_chk = 0, n_fail = 0, exp_cnt = 0;

    always #5 clk = ~clk;

    sysbus_router #(.CNT_W(CW)) dut (.*);

    function automatic logic [31:0] port_model(int p, logic [31:0] a);
        return (a * 32'h9E3779B1) ^ {p[7:0], 24'h5A5A5A};
    endfunction

    always_comb begin
        for (int p = 0; p < 8; p++) tgt_rdata[p*32 +: 32] = port_model(p, tgt_addr);
        bk_rdata = bk_addr[7:0] ^ bk_addr[15:8] ^ 8'h3C;
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rotr(logic [31:0] w, int sh);
        logic [63:0] d = {w, w} >> sh;
        return d[31:0];
    endfunction

    task automatic access(bit v, bit we, logic [1:0] sz, logic [31:0] a, logic [31:0] wd, logic [15:0] dc);
        logic [7:0]  pg;
        int          port;
        logic [31:0] al, exp_rd, raw;
        logic [7:0]  exp_sel, bb;
        bit          exp_bk, exp_err;
        int          sh, nl;
        @(negedge clk);
        chk("R8 count", 64'(acc_count), 64'(exp_cnt % (1 << CW)));
        req_valid = v; req_we = we; req_size = sz; req_addr = a; req_wdata = wd; disp_ctrl = dc;
        #2;
        pg = a[31:24];
        port = -1; exp_bk = 0; exp_err = 0;
        if (pg == 8'h00) port = 0;
        else if (pg >= 8'h02 && pg <= 8'h07) port = pg - 1;
        else if (pg >= 8'h08 && pg <= 8'h0D) port = we ? -1 : 7;
        else if (pg == 8'h0E || pg == 8'h0F) exp_bk = 1;
        else exp_err = 1;
        if (!v) begin port = -1; exp_bk = 0; exp_err = 0; end
        al = (sz == 2'b00) ? a : (sz == 2'b01) ? {a[31:1], 1'b0} : {a[31:2], 2'b00};
        exp_sel = (port >= 0) ? 8'(1 << port) : 8'h00;
        exp_rd = 0;
        nl = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        if (v && !we && port >= 0) begin
            raw = port_model(port, al);
            exp_rd = (nl == 1) ? {24'h0, raw[7:0]} : (nl == 2) ? {16'h0, raw[15:0]} : raw;
        end
        if (v && !we && exp_bk) begin
            bb = a[7:0] ^ a[15:8] ^ 8'h3C;
            for (int l = 0; l < nl; l++) exp_rd[l*8 +: 8] = bb;
        end
        chk("R1 sel", 64'(tgt_sel), 64'(exp_sel));
        if (pg >= 8'h08 && pg <= 8'h0D) chk("R2 cart", 64'(tgt_sel), 64'(exp_sel));
        chk("R3 bk_sel", 64'(bk_sel), 64'(exp_bk));
        chk("R7 err", 64'(rsp_err), 64'(exp_err));
        if (exp_bk && !we) chk("R4 save read", 64'(rsp_rdata), 64'(exp_rd));
        else if (exp_err) chk("R7 rdata", 64'(rsp_rdata), 64'h0);
        else chk("R10 rdata", 64'(rsp_rdata), 64'(exp_rd));
        if (port >= 0) chk("R6 addr", 64'(tgt_addr), 64'(al));
        if (exp_bk) begin
            chk("R3 bk_addr", 64'(bk_addr), 64'(a));
            if (we) begin
                sh = (sz == 2'b00) ? 0 : (sz == 2'b01) ? 8 * a[0] : 8 * a[1:0];
                chk("R5 lane", 64'(bk_wbyte), 64'(rotr(wd, sh) & 32'hFF));
            end
        end
        chk("R9 vram_ctrl", 64'(vram_ctrl), (v && we && pg == 8'h06) ? 64'(dc) : 64'h0);
        @(posedge clk);
        if (v) exp_cnt++;
    endtask

    initial begin
        #2000000;
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] pg;
        void'($urandom(32'd4242));
        #1;
        chk("R8 reset count", 64'(acc_count), 64'h0);
        repeat (3) @(posedge clk);
        rst_n = 1;
        // directed corners
        access(0, 0, 2'b10, 32'h0800_0000, 0, 16'h1234);        // R1 idle, no count
        access(1, 1, 2'b10, 32'h0900_0010, 32'hDEAD, 16'h1);    // R2 cart write dropped
        access(1, 0, 2'b01, 32'h0D00_0006, 0, 0);               // R2 cart read
        access(1, 1, 2'b10, 32'h0E00_0003, 32'h1122_3344, 0);   // R5 word lane 3 -> 0x11
        access(1, 1, 2'b01, 32'h0F00_0001, 32'h1122_3344, 0);   // R5 half lane 1 -> 0x33
        access(1, 1, 2'b00, 32'h0E00_0002, 32'h1122_3344, 0);   // R5 byte -> 0x44
        access(1, 0, 2'b10, 32'h0E00_0101, 0, 0);               // R4 word replication
        access(1, 0, 2'b01, 32'h0F00_0022, 0, 0);               // R4 half replication
        access(1, 0, 2'b00, 32'h0100_0000, 0, 0);               // R7 page 0x01
        access(1, 1, 2'b10, 32'hFF00_0000, 32'h5, 0);           // R7 high page write
        access(1, 1, 2'b01, 32'h0600_0003, 32'h77, 16'hBEEF);   // R9 vram write
        access(1, 0, 2'b11, 32'h0300_0007, 0, 0);               // R10 reserved size as word
        access(1, 0, 2'b00, 32'h0000_0003, 0, 0);               // R6/R10 byte unchanged addr
        for (int i = 0; i < 400; i++) begin
            pg = ($urandom % 9 == 0) ? 8'hFF : 8'($urandom % 20);
            access($urandom % 8 != 0, 1'($urandom), 2'($urandom), {pg, 24'($urandom)},
                   $urandom, 16'($urandom));
        end
        access(0, 0, 0, 0, 0, 0);  // final counter check (R8)
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule